// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the status byte that a memory controller returns to the host on every read issued while a byte program or a sector/chip erase is pending, running or stuck past its time limit. The controller tells it which kind of operation is active, the data bit that the program is writing, the phase the operation is in, and which sectors are selected for erase. The host reads the byte repeatedly: it compares the top bit against its own data, watches two bits that flip from one read to the next, and reads a latched flag for a failed operation.

Each read is marked by a strobe that stays high for one or more clock cycles. The toggle state advances once per read, on the first clock edge that sees the strobe high. The erase-only toggle bit advances only when the read falls in a sector selected for erase. So the host can tell which sectors are still being erased. The time-limit flag is latched and is cleared only by an explicit clear pulse, which stands for the host's reset command. Returning array data after completion is done outside this block.

Top module: `opstat_gen`

## Requirements
- R1: When `op_erase` is 0 (program), `status[7]` equals the inverse of `prog_bit7` in every phase except done. In the done phase it equals `prog_bit7`.
- R2: When `op_erase` is 1 (erase), `status[7]` is 0 in every phase except done, and 1 in the done phase. The phase encoding is 0 = window, 1 = running, 2 = done, 3 = timeout.
- R3: `status[6]` inverts once for each read (a rising edge of `rd_strobe`) that is sampled while the phase is not done. The new value appears after the clock edge that samples the strobe high for the first time.
- R4: While the phase is done, reads leave `status[6]` unchanged.
- R5: `status[5]` is 1 whenever the phase is timeout.
- R6: Once a timeout has been seen, `status[5]` stays 1 until a `tmo_clear` pulse is sampled. If a clear and the timeout phase are sampled in the same cycle, the flag stays set.
- R7: For an erase, `status[3]` is 0 in the window phase and 1 in any other phase. For a program it is 0.
- R8: For an erase that is not done, `status[2]` inverts on a read only when the sector index `rd_addr[ADDR_W-1 -: SECT_W]` has its bit set in `erase_sel`. Reads of any other sector leave it unchanged. In the done phase of an erase, `status[2]` reads 1.
- R9: For a program, `status[2]` reads 1, and program reads do not advance the erase toggle state.
- R10: A strobe that stays high for several cycles counts as one read: `status[6]` and `status[2]` change at most once during it.
- R11: Reset clears both toggle states and the timeout flag. Bits 4, 1 and 0 of `status` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_strobe | input | 1 | High during a host read of the status |
| rd_addr | input | ADDR_W | Address of the read |
| op_erase | input | 1 | 1 = erase operation, 0 = program operation |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| phase | input | 2 | 0 window, 1 running, 2 done, 3 timeout |
| erase_sel | input | NUM_SECT | One bit per sector selected for erase |
| tmo_clear | input | 1 | Clear pulse for the timeout flag (reset command) |
| status | output | 8 | Status byte |

## Verification
Two things can happen in one cycle: setting the latched timeout flag and clearing it. The bench holds the timeout phase and pulses `tmo_clear` in the same cycle. It then moves the phase to running and expects bit 5 to stay 1. A clear pulse on its own must then bring bit 5 back to 0. Read strobes also arrive in the same cycle as phase changes, and a strobe held high for several cycles must give exactly one toggle step.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
   typedef enum logic [1:0] {
      PH_WINDOW = 2'd0,
      PH_RUN    = 2'd1,
      PH_DONE   = 2'd2,
      PH_TMO    = 2'd3
   } phase_e;

   localparam int STATUS_W = 8;
   localparam int B_POLL   = 7;
   localparam int B_TOG    = 6;
   localparam int B_TMO    = 5;
   localparam int B_ERS    = 3;
   localparam int B_SECTOG = 2;
endpackage

// File: rtl/opstat_edge.sv
module opstat_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/opstat_sector_hit.sv
module opstat_sector_hit #(
   parameter int ADDR_W = 19,
   parameter int SECT_W = 3,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_SECT-1:0] sel,
   output logic                hit
);
   logic [SECT_W-1:0]   sect_idx;
   logic [NUM_SECT-1:0] match;

   assign sect_idx = addr[ADDR_W-1 -: SECT_W];

   for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      assign match[s] = sel[s] && (sect_idx == SECT_W'(s));
   end

   assign hit = |match;
endmodule

// File: rtl/opstat_flag.sv
module opstat_flag #(
   parameter bit TOGGLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_or_flip,
   input  logic clr,
   output logic q
);
   if (TOGGLE) begin : g_toggle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           q <= 1'b0;
         else if (set_or_flip) q <= ~q;
      end
   end else begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           q <= 1'b0;
         else if (set_or_flip) q <= 1'b1;
         else if (clr)         q <= 1'b0;
      end
   end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
   import opstat_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int SECT_W = 3,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_strobe,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic                op_erase,
   input  logic                prog_bit7,
   input  logic [1:0]          phase,
   input  logic [NUM_SECT-1:0] erase_sel,
   input  logic                tmo_clear,
   output logic [STATUS_W-1:0] status
);
   if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
      $error("opstat_gen: SECT_W must lie in 1..ADDR_W");
   end
   if (NUM_SECT > 64) begin : g_bad_count
      $error("opstat_gen: too many sectors");
   end

   logic rd_rise, sect_hit;
   logic active, is_tmo, is_done, is_window;
   logic tog_all_q, tog_sect_q, tmo_q;

   assign is_done   = (phase == PH_DONE);
   assign is_tmo    = (phase == PH_TMO);
   assign is_window = (phase == PH_WINDOW);
   assign active    = ~is_done;

   opstat_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (rd_strobe),
      .rise  (rd_rise)
   );

   opstat_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_hit (
      .addr (rd_addr),
      .sel  (erase_sel),
      .hit  (sect_hit)
   );

   opstat_flag #(.TOGGLE(1'b1)) u_tog_all (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_or_flip (rd_rise & active),
      .clr         (1'b0),
      .q           (tog_all_q)
   );

   opstat_flag #(.TOGGLE(1'b1)) u_tog_sect (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_or_flip (rd_rise & active & op_erase & sect_hit),
      .clr         (1'b0),
      .q           (tog_sect_q)
   );

   opstat_flag #(.TOGGLE(1'b0)) u_tmo (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_or_flip (is_tmo),
      .clr         (tmo_clear),
      .q           (tmo_q)
   );

   always_comb begin
      status           = '0;
      status[B_POLL]   = op_erase ? is_done : (is_done ? prog_bit7 : ~prog_bit7);
      status[B_TOG]    = tog_all_q;
      status[B_TMO]    = tmo_q | is_tmo;
      status[B_ERS]    = op_erase & ~is_window;
      status[B_SECTOG] = op_erase ? (is_done | tog_sect_q) : 1'b1;
   end
endmodule

// File: rtl/opstat_gen_chk.sv
module opstat_gen_chk #(
   parameter int NUM_SECT = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_strobe,
   input logic                op_erase,
   input logic                prog_bit7,
   input logic [1:0]          phase,
   input logic                tmo_clear,
   input logic [7:0]          status
);
   logic strb_q, past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q  <= 1'b0;
         past_ok <= 1'b0;
      end else begin
         strb_q  <= rd_strobe;
         past_ok <= 1'b1;
      end
   end

   a_r1_prog_poll_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_erase && phase != 2'd2) |-> (status[7] == !prog_bit7));
   a_r1_prog_poll_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_erase && phase == 2'd2) |-> (status[7] == prog_bit7));
   a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      op_erase |-> (status[7] == (phase == 2'd2)));
   a_r3_tog_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !strb_q && phase != 2'd2) |=> (status[6] != $past(status[6])));
   a_r4_tog_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd2) |=> $stable(status[6]));
   a_r5_tmo_now: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd3) |-> status[5]);
   a_r6_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(status[5]) && !$past(tmo_clear)) |-> status[5]);
   a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
      op_erase |-> (status[3] == (phase != 2'd0)));
   a_r9_prog_b2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_erase |-> status[2]);
   a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rd_strobe && strb_q) |=> $stable(status[6]));
endmodule

bind opstat_gen opstat_gen_chk #(.NUM_SECT(NUM_SECT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_strobe (rd_strobe),
   .op_erase  (op_erase),
   .prog_bit7 (prog_bit7),
   .phase     (phase),
   .tmo_clear (tmo_clear),
   .status    (status)
);

// File: tb/test_opstat_gen.sv
module test_opstat_gen;
   localparam int ADDR_W = 19;
   localparam int SECT_W = 3;
   localparam int NS     = 1 << SECT_W;

   typedef struct packed {
      logic              op;
      logic              d7;
      logic [1:0]        ph;
      logic [NS-1:0]     sel;
      logic [ADDR_W-1:0] addr;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 2'd0, 8'h04, 19'h20010},
      '{1'b1, 1'b0, 2'd1, 8'h04, 19'h20020},
      '{1'b1, 1'b0, 2'd1, 8'h04, 19'h50000},
      '{1'b1, 1'b1, 2'd1, 8'hA0, 19'h70000},
      '{1'b1, 1'b0, 2'd2, 8'h04, 19'h20000},
      '{1'b0, 1'b1, 2'd1, 8'hFF, 19'h00100},
      '{1'b0, 1'b0, 2'd1, 8'hFF, 19'h10100},
      '{1'b0, 1'b1, 2'd2, 8'hFF, 19'h10100},
      '{1'b0, 1'b1, 2'd3, 8'h00, 19'h30000},
      '{1'b0, 1'b1, 2'd1, 8'h00, 19'h30000},
      '{1'b1, 1'b0, 2'd3, 8'h01, 19'h00003},
      '{1'b1, 1'b0, 2'd0, 8'h01, 19'h40003}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_strobe = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              op_erase = 1'b1;
   logic              prog_bit7 = 1'b0;
   logic [1:0]        phase = 2'd1;
   logic [NS-1:0]     erase_sel = '0;
   logic              tmo_clear = 1'b0;
   logic [7:0]        status;

   int n_chk = 0;
   int n_fail = 0;
   logic m_t6 = 1'b0, m_t2 = 1'b0, m_tmo = 1'b0;

   always #5 clk = ~clk;

   opstat_gen #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_opstat_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_strobe (rd_strobe),
      .rd_addr   (rd_addr),
      .op_erase  (op_erase),
      .prog_bit7 (prog_bit7),
      .phase     (phase),
      .erase_sel (erase_sel),
      .tmo_clear (tmo_clear),
      .status    (status)
   );

   task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_byte();
      logic [7:0] b = '0;
      logic done = (phase == 2'd2);
      b[7] = op_erase ? done : (done ? prog_bit7 : ~prog_bit7);
      b[6] = m_t6;
      b[5] = m_tmo | (phase == 2'd3);
      b[3] = op_erase & (phase != 2'd0);
      b[2] = op_erase ? (done | m_t2) : 1'b1;
      return b;
   endfunction

   // every field is judged on its own so a failure names its requirement
   task automatic check_all(input string ctx);
      logic [7:0] e = model_byte();
      check(status[7] == e[7], op_erase ? {"R2 poll ", ctx} : {"R1 poll ", ctx}, status, e);
      check(status[6] == e[6], (phase == 2'd2) ? {"R4 toggle ", ctx} : {"R3 toggle ", ctx}, status, e);
      check(status[5] == e[5], {"R5 R6 timeout ", ctx}, status, e);
      check(status[3] == e[3], {"R7 window ", ctx}, status, e);
      check(status[2] == e[2], op_erase ? {"R8 sector toggle ", ctx} : {"R9 program b2 ", ctx}, status, e);
      check((status & 8'h13) == 8'h00, {"R11 zero bits ", ctx}, status, e);
   endtask

   // model update for a clock edge seen with the current inputs
   task automatic model_edge(input logic rise);
      if (rise && phase != 2'd2) begin
         m_t6 = ~m_t6;
         if (op_erase && erase_sel[rd_addr[ADDR_W-1 -: SECT_W]]) m_t2 = ~m_t2;
      end
      if (phase == 2'd3)  m_tmo = 1'b1;
      else if (tmo_clear) m_tmo = 1'b0;
   endtask

   task automatic do_read(input int hold);
      @(negedge clk) rd_strobe = 1'b1;
      for (int c = 0; c < hold; c++) begin
         @(posedge clk);
         model_edge(c == 0);
         #1;
      end
      @(negedge clk) rd_strobe = 1'b0;
      @(posedge clk);
      model_edge(1'b0);
      #1;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state with an erase running
      check(status == 8'h08, "R11 reset state", status, 8'h08);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_all("after reset");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_erase  = VECS[i].op;
         prog_bit7 = VECS[i].d7;
         phase     = VECS[i].ph;
         erase_sel = VECS[i].sel;
         rd_addr   = VECS[i].addr;
         do_read(1);
         check_all($sformatf("vector %0d", i));
      end

      // R10: strobe held four cycles counts once
      @(negedge clk);
      op_erase = 1'b1; phase = 2'd1; erase_sel = 8'h08; rd_addr = 19'h30000;
      do_read(4);
      check_all("R10 long strobe");

      // R6: clear together with timeout phase keeps the flag
      @(negedge clk);
      phase = 2'd3; tmo_clear = 1'b1;
      @(posedge clk); model_edge(1'b0); #1;
      @(negedge clk);
      phase = 2'd1; tmo_clear = 1'b0;
      @(posedge clk); model_edge(1'b0); #1;
      check(status[5] == 1'b1, "R6 clear with timeout same cycle", status, 8'h20);
      check_all("R6 after collision");

      // R6: lone clear drops the flag
      @(negedge clk) tmo_clear = 1'b1;
      @(posedge clk); model_edge(1'b0); #1;
      @(negedge clk) tmo_clear = 1'b0;
      #1;
      check(status[5] == 1'b0, "R6 clear alone", status, 8'h00);

      // R4: several reads in done phase leave bit 6
      @(negedge clk) phase = 2'd2;
      do_read(1);
      do_read(2);
      check_all("R4 done reads");

      // R9: program read in a selected sector leaves erase toggle state
      @(negedge clk) op_erase = 1'b0; phase = 2'd1; erase_sel = 8'hFF;
      do_read(1);
      @(negedge clk) op_erase = 1'b1;
      #1;
      check_all("R9 erase state after program read");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule